// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Emulator

This block is a clocked, synthesizable stand-in for a byte-wide one-time-programmable memory. It is meant for a testbench or an FPGA prototype. All control pins are digital levels sampled in the emulator clock: an active-low chip select, an active-low output enable, a flag that marks the program supply pin as being at high voltage, and a flag that marks address line 9 as being at high voltage. From these the block decodes the operating mode. It then either returns a stored byte or one of two identification bytes, or it disables its outputs. A program pulse can only clear bits, never set them.

The address width is a parameter. The full-size part uses 16 bits (65536 bytes); the default is 10 bits so that the default elaboration stays small. A synchronous erase-all request stands in for ultraviolet exposure. It rewrites every word to all ones, one word per cycle, and raises a busy flag while it runs. A tri-state pad is modelled as a data value plus a drive-enable flag. When the outputs are in high impedance, the data value is zero.

Top module: `eprom_emu`

## Requirements
- R1: A one-cycle pulse on `erase_req` while idle keeps `busy` high for exactly 2^ADDR_W cycles. Afterwards every address reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hi`=0 (read), `dq_oe` is 1 and `dq_out` is the byte stored at `addr`.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, `dq_oe` is 0.
- R4: With `ce_n`=1, `dq_oe` is 0 whatever `oe_n`, `vpp_hi` and `a9_hi` are.
- R5: A program pulse writes a byte. The pulse is `ce_n` low with `vpp_hi`=1 and `oe_n`=1, ended by `ce_n` going high. The word at the address held during the pulse becomes its old value ANDed with `din`. `dq_oe` stays 0 during the pulse.
- R6: With `ce_n`=0, `vpp_hi`=1 and `oe_n`=0 (verify), the stored byte is driven whatever `a9_hi` is. Ending such a pulse writes nothing.
- R7: With read conditions and `a9_hi`=1, `dq_out` is 0x20 when `addr[0]`=0 and 0x3D when `addr[0]`=1, with `dq_oe`=1.
- R8: In identification mode, `id_err` is 1 when any of `addr[ADDR_W-1:1]` is nonzero. Otherwise `id_err` is 0.
- R9: Outputs follow the inputs sampled at the clock edge two edges earlier. After a single edge they still show the previous mode.
- R10: While `busy` is high, `dq_oe` is 0, program pulses are ignored and further erase requests are ignored.
- R11: Whenever `dq_oe` is 0, `dq_out` is 0x00. After reset `dq_oe`, `id_err` and `busy` are 0.
- R12: Toggling `ce_n` low-to-high while `vpp_hi`=1 writes nothing unless `ce_n` was low with `oe_n`=1 in the preceding sampled cycles. In particular, holding `ce_n` high with `vpp_hi`=1 (inhibit) never writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low; its rising edge ends a program pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Program supply pin at high voltage |
| a9_hi | input | 1 | Address line 9 at high voltage (identification) |
| din | input | 8 | Byte to program |
| erase_req | input | 1 | Start erase-all |
| dq_out | output | 8 | Data value seen on the pads |
| dq_oe | output | 1 | Pads are driven |
| id_err | output | 1 | Identification read with stray address bits |
| busy | output | 1 | Erase sweep in progress |

## Verification
Random mixes of read, program, verify, identification, output-disable and standby operations run against a bench memory model. Random program data exposes any write that sets a bit instead of clearing it. Interleaved verify pulses with zero `din` would corrupt the model if a verify pulse ever wrote. Directed cases cover the rest: a program pulse and an erase request issued during an erase, an inhibit toggle, identification with stray address bits, and a one-edge sample that separates the two-stage latency from a one-stage one.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] ID_MAKER = 8'h20;
  localparam logic [DATA_W-1:0] ID_PART  = 8'h3D;

  typedef enum logic [2:0] {
    MD_OFF,
    MD_READ,
    MD_IDENT,
    MD_VERIFY,
    MD_PROG
  } mode_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic vpp;
    logic a9;
  } pins_t;
endpackage

// File: rtl/eprom_pin_sampler.sv
module eprom_pin_sampler
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic [DATA_W-1:0] din,
  input  logic              erase_req,
  output pins_t             pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q,
  output logic              erase_q
);
  pins_t pins_d;

  always_comb begin
    pins_d.ce_n = ce_n;
    pins_d.oe_n = oe_n;
    pins_d.vpp  = vpp_hi;
    pins_d.a9   = a9_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= '{ce_n: 1'b1, oe_n: 1'b1, vpp: 1'b0, a9: 1'b0};
      addr_q  <= '0;
      din_q   <= '0;
      erase_q <= 1'b0;
    end else begin
      pins_q  <= pins_d;
      addr_q  <= addr;
      din_q   <= din;
      erase_q <= erase_req;
    end
  end
endmodule

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  pins_t pins_q,
  input  logic  busy,
  output mode_e mode
);
  always_comb begin
    mode = MD_OFF;
    if (!busy && !pins_q.ce_n) begin
      if (pins_q.vpp) begin
        mode = pins_q.oe_n ? MD_PROG : MD_VERIFY;
      end else if (!pins_q.oe_n) begin
        mode = pins_q.a9 ? MD_IDENT : MD_READ;
      end
    end
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              ce_n_q,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] din_q,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  logic              armed_q, armed_d;
  logic              cap_en;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    cap_en  = (mode == MD_PROG);
    armed_d = cap_en;
    waddr_d = cap_en ? addr_q : waddr_q;
    wdata_d = cap_en ? din_q  : wdata_q;
    we      = armed_q && ce_n_q && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      armed_q <= armed_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign waddr = waddr_q;
  assign wdata = wdata_q;

  AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we); // R5
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_q,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (erase_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      cells[cnt_q] <= '1;
    end else if (we) begin
      cells[waddr] <= cells[waddr] & wdata;
    end
    rd_q <= cells[raddr];
  end

  assign rd_data = rd_q;
  assign busy    = busy_q;

  AST_ERASE_FULL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cnt_q) == LAST); // R1
  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !we); // R10
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic [7:0]        din,
  input  logic              erase_req,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              id_err,
  output logic              busy
);
  pins_t             pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              erase_q;
  mode_e             mode;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_data;
  logic              busy_w;

  logic oe_q, oe_d;
  logic ident_q, ident_d;
  logic a0_q, a0_d;
  logic err_q, err_d;

  eprom_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .din(din), .erase_req(erase_req),
    .pins_q(pins_q), .addr_q(addr_q), .din_q(din_q), .erase_q(erase_q)
  );

  eprom_mode_decode u_decode (
    .pins_q(pins_q), .busy(busy_w), .mode(mode)
  );

  eprom_prog_seq #(.ADDR_W(ADDR_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ce_n_q(pins_q.ce_n),
    .busy(busy_w), .addr_q(addr_q), .din_q(din_q),
    .we(we), .waddr(waddr), .wdata(wdata)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_q(erase_q), .we(we),
    .waddr(waddr), .wdata(wdata), .raddr(addr_q),
    .rd_data(rd_data), .busy(busy_w)
  );

  always_comb begin
    oe_d    = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
    ident_d = (mode == MD_IDENT);
    a0_d    = addr_q[0];
    err_d   = (mode == MD_IDENT) && (|addr_q[ADDR_W-1:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      ident_q <= 1'b0;
      a0_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      oe_q    <= oe_d;
      ident_q <= ident_d;
      a0_q    <= a0_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    if (!oe_q) begin
      dq_out = '0;
    end else if (ident_q) begin
      dq_out = a0_q ? ID_PART : ID_MAKER;
    end else begin
      dq_out = rd_data;
    end
  end

  assign dq_oe  = oe_q;
  assign id_err = err_q;
  assign busy   = busy_w;

  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(ce_n, 2)); // R4
  AST_QUIET_WHILE_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dq_oe); // R10
  AST_ERR_CODE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> (dq_out == ID_MAKER || dq_out == ID_PART)); // R7
  AST_ERR_NEEDS_A9: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> $past(a9_hi, 2)); // R8
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 8'h00); // R11
endmodule

// File: tb/eprom_emu_tb.sv
module eprom_emu_tb_top;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              ce_n, oe_n, vpp_hi, a9_hi, erase_req;
  logic [7:0]        din;
  logic [7:0]        dq_out;
  logic              dq_oe, id_err, busy;

  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  eprom_emu #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .din(din), .erase_req(erase_req),
    .dq_out(dq_out), .dq_oe(dq_oe), .id_err(id_err), .busy(busy)
  );

  function automatic logic [7:0] exp_ident(logic [ADDR_W-1:0] a);
    return a[0] ? 8'h3D : 8'h20;
  endfunction

  function automatic logic exp_err(logic [ADDR_W-1:0] a);
    return |a[ADDR_W-1:1];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_pins();
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; a9_hi = 1'b0; din = '0;
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; a9_hi = 1'b0;
    settle();
    chk("R2 read drive", dq_oe, 1);
    chk("R2 read data", dq_out, model[a]);
  endtask

  task automatic do_prog(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0; a9_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 pulse quiet", dq_oe, 0);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    vpp_hi = 1'b0;
    model[a] = model[a] & d;
  endtask

  task automatic do_verify(logic [ADDR_W-1:0] a, logic a9);
    @(negedge clk);
    addr = a; din = 8'h00; vpp_hi = 1'b1; oe_n = 1'b0; ce_n = 1'b0; a9_hi = a9;
    settle();
    chk("R6 verify drive", dq_oe, 1);
    chk("R6 verify data", dq_out, model[a]);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    vpp_hi = 1'b0; oe_n = 1'b1; a9_hi = 1'b0;
  endtask

  task automatic do_ident(logic [ADDR_W-1:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; a9_hi = 1'b1;
    settle();
    chk("R7 id drive", dq_oe, 1);
    chk("R7 id code", dq_out, exp_ident(a));
    chk("R8 id error flag", id_err, exp_err(a));
    a9_hi = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; addr = '0; erase_req = 1'b0;
    idle_pins();
    repeat (5) @(negedge clk);
    chk("R11 reset drive", dq_oe, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset id_err", id_err, 0);
    chk("R11 reset data", dq_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: erase with a stray program pulse, erase request and read inside it
    busy_cnt = 0;
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    for (int i = 0; i < DEPTH + 40; i++) begin
      if (busy) busy_cnt++;
      if (i == 100) begin addr = 5; din = 8'h00; vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0; end
      if (i == 110) ce_n = 1'b1;
      if (i == 120) begin vpp_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b0; end
      if (i == 130) begin
        chk("R10 no drive while busy", dq_oe, 0);
        chk("R11 data zero when quiet", dq_out, 0);
        erase_req = 1'b1;
      end
      if (i == 131) erase_req = 1'b0;
      @(negedge clk);
    end
    idle_pins();
    chk("R1 busy span", busy_cnt, DEPTH);
    chk("R10 erase not restarted", busy, 0);
    for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    for (int k = 0; k < DEPTH; k++) do_read(ADDR_W'(k));

    // R9: one edge is not enough
    @(negedge clk);
    idle_pins();
    repeat (3) @(negedge clk);
    addr = 7; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 still quiet after one edge", dq_oe, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drive after two edges", dq_oe, 1);

    // R3 output disable, R4 standby
    oe_n = 1'b1;
    settle();
    chk("R3 disable", dq_oe, 0);
    chk("R11 disable data", dq_out, 0);
    ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b1; a9_hi = 1'b1;
    settle();
    chk("R4 standby", dq_oe, 0);
    idle_pins();

    // R5 directed clear-only writes
    do_prog(3, 8'hA5);
    do_read(3);
    chk("R5 first write", model[3], 8'hA5);
    do_prog(3, 8'h0F);
    do_read(3);
    do_prog(3, 8'hFF);
    do_read(3);
    chk("R5 and result", model[3], 8'h05);

    // R6 verify with a9 high, and no write on its end
    do_verify(3, 1'b1);
    do_read(3);

    // R12 inhibit toggle: ce high with vpp high, then edges without a program low phase
    @(negedge clk);
    addr = 3; din = 8'h00; vpp_hi = 1'b1; oe_n = 1'b0; ce_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 inhibit quiet", dq_oe, 0);
    ce_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_pins();
    do_read(3);
    chk("R12 inhibit no write", model[3], 8'h05);

    // R7 / R8 identification corners
    do_ident(0);
    do_ident(1);
    do_ident(2);
    do_ident(ADDR_W'(1) << (ADDR_W - 1));
    do_ident('1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [ADDR_W-1:0] ra;
      logic [7:0] rd;
      int op;
      ra = ADDR_W'($urandom);
      rd = 8'($urandom);
      op = int'($urandom % 6);
      case (op)
        0: do_read(ra);
        1: do_prog(ra, rd);
        2: do_verify(ra, 1'($urandom));
        3: do_ident(($urandom % 2) ? ADDR_W'(ra[0]) : ra);
        4: begin
          @(negedge clk);
          addr = ra; ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b0; a9_hi = 1'($urandom);
          settle();
          chk("R3 random disable", dq_oe, 0);
          a9_hi = 1'b0;
        end
        default: begin
          @(negedge clk);
          addr = ra; ce_n = 1'b1; oe_n = 1'($urandom); vpp_hi = 1'($urandom);
          a9_hi = 1'($urandom);
          settle();
          chk("R4 random standby", dq_oe, 0);
          idle_pins();
        end
      endcase
    end
    for (int k = 0; k < 64; k++) do_read(ADDR_W'(k * 16 + 3));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule